// File: doc/BRIEF.md
# Dual-Set Flash Command Interpreter

This block turns a stream of byte writes on a parallel bus into the operations of a flash device. Two incompatible command conventions share one decoder. In the first, a single command byte picks what happens next. In the second, two fixed address/data unlock writes must come before the operative byte. A small on-chip byte array stands in for the flash cells. Reads of the block return the array, an identification byte or the status byte, depending on the mode that the last command left behind.

Programming is immediate. An erase sweeps the selected range to 0xFF at one byte per clock. A separate busy timer emulates the device's erase time, scaled to clock ticks. While that timer runs, the status byte reports the operation in progress. When it expires, the ready bit returns. A master lock flag is set and cleared through its own two-write command and is brought out on a port.

Top module: `flash_cmd_interp`

## Requirements
- R1: After reset the read mode is array (rd_mode 0), the master lock is clear and the status byte is 0x80.
- R2: rd_mode encodes array as 0, ID as 1 and status as 2. From any read mode (array, status, ID, or ID reached through unlock), 0xF0 or 0xFF selects array read, 0x90 selects ID read and 0x70 selects status read. In ID mode, rd_addr bit 0 low returns MFR_ID and high returns DEV_ID.
- R3: Command 0x50 loads 0x80 into the status byte and selects status read, even while an erase timer is still running.
- R4: After 0x40 or 0x10, the next write stores its data byte at its address, sets the status to 0x80 and selects status read.
- R5: After 0x20, a 0xD0 write erases the aligned 2^BLOCK_LOG2-byte block holding its address and sets the status to 0x00 in status read. Any other byte is ignored and the block stays armed, still reading status.
- R6: After 0x60, 0xF1 sets the master lock, 0xD0 clears it, and any other byte leaves it unchanged. The mode returns to array read in every case.
- R7: 0xAA with address bits [11:0] = 0x555 starts the unlock. The second write must be 0x55 at address 0x2AA or 0x2AAA (bits [15:0]); anything else returns to array mode with no operation armed.
- R8: The third unlock write, at 0x555 or 0x5555, decodes as follows: 0x90 selects ID read, 0xA0 arms a single-byte program that stores the next write and returns to array mode, 0x80 starts the erase prefix, and 0xF0 returns to array mode. Any other byte, or any other address, returns to array mode.
- R9: The erase prefix then takes 0xAA at 0x555 and 0x55 at 0x2AA or 0x2AAA, in that order, followed by the erase command. A write that does not match the expected step is ignored and the step is kept.
- R10: Erase command 0x10 at 0x555 erases the whole array to 0xFF. After any unlock erase command, the mode is status read with status 0x08, and writes are ignored until the timer expires.
- R11: Erase command 0x30 at any address erases only the aligned sector holding that address; bytes outside the sector keep their values.
- R12: When a busy timer expires, status bit 7 is set and bit 3 cleared. An unlock erase then returns to array read.
- R13: Bus writes that arrive while an erase sweep is still clearing bytes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | BUS_AW | Bus write address |
| wr_data | input | 8 | Bus write data / command byte |
| rd_addr | input | ARR_AW | Read address |
| rd_data | output | 8 | Array byte, ID byte or status byte per read mode |
| rd_mode | output | 2 | Current read mode: 0 array, 1 ID, 2 status |
| master_lock | output | 1 | Master lock flag |

## Verification
The bench builds the block with a 2 KiB array, 256-byte sectors and 1 KiB blocks. Busy times are 300, 1200 and 2100 ticks for sector, block and chip erase. With these sizes, a whole-chip sweep and both expiry paths fit within a few thousand cycles. Windows are left between the end of a sweep and the end of its timer, so dropped writes, writes ignored in the erase wait, and 0x50 during a running timer can each be observed. Sector and block boundaries sit close enough that bytes on both sides of an erased range can be checked.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_ID     = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [3:0] {
    ST_NORMAL,
    ST_STATUS,
    ST_ID,
    ST_UID,
    ST_UNLK1,
    ST_UNLK2,
    ST_PROG_ARM,
    ST_BLK_ARM,
    ST_LOCK_ARM,
    ST_BYTE_PROG,
    ST_ERP1,
    ST_ERP2,
    ST_ERP3,
    ST_ERASE_WAIT
  } cmd_state_e;

  typedef enum logic [1:0] {
    ER_SECTOR = 2'd0,
    ER_BLOCK  = 2'd1,
    ER_CHIP   = 2'd2
  } erase_kind_e;

  localparam logic [7:0] STATUS_READY = 8'h80;
  localparam logic [7:0] STATUS_ERBSY = 8'h08;

endpackage

// File: rtl/fcmd_busy_timer.sv
module fcmd_busy_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  assign expire = run_q && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R12: expiry is a single-cycle pulse
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array #(
  parameter int ARR_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ARR_AW-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              er_start,
  input  logic [ARR_AW-1:0] er_base,
  input  logic [ARR_AW-1:0] er_last,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              sweep_busy
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [7:0]        mem_q [DEPTH];
  logic              sweep_q, sweep_d;
  logic [ARR_AW-1:0] ptr_q, ptr_d;
  logic [ARR_AW-1:0] last_q, last_d;
  logic              mem_we;
  logic [ARR_AW-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  assign sweep_busy = sweep_q;
  assign rd_byte    = mem_q[rd_addr];

  always_comb begin
    sweep_d = sweep_q;
    ptr_d   = ptr_q;
    last_d  = last_q;
    if (er_start) begin
      sweep_d = 1'b1;
      ptr_d   = er_base;
      last_d  = er_last;
    end else if (sweep_q) begin
      ptr_d = ptr_q + ARR_AW'(1);
      if (ptr_q == last_q) sweep_d = 1'b0;
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = prog_addr;
    mem_wdata = prog_data;
    if (sweep_q) begin
      mem_we    = 1'b1;
      mem_waddr = ptr_q;
      mem_wdata = 8'hFF;
    end else if (prog_we) begin
      mem_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[mem_waddr] <= mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= 1'b0;
      ptr_q   <= '0;
      last_q  <= '0;
    end else begin
      sweep_q <= sweep_d;
      ptr_q   <= ptr_d;
      last_q  <= last_d;
    end
  end

  // R11: the sweep stops right after the last byte of its range
  p_sweep_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_q && ptr_q == last_q && !er_start) |=> !sweep_q);

  // R13: a program write never reaches the array while sweeping
  p_no_prog_in_sweep_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_q |-> !prog_we);

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int BUS_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy_expire,
  output rd_mode_e          rd_mode,
  output logic [7:0]        status,
  output logic              master_lock,
  output logic              prog_we,
  output logic              erase_start,
  output erase_kind_e       erase_kind
);

  cmd_state_e  state_q, state_d;
  logic [7:0]  status_q, status_d;
  logic        lock_q, lock_d;
  logic [11:0] a12;
  logic [15:0] a16;
  logic        at_555_12, at_2aa, at_555_16;

  assign a12       = wr_addr[11:0];
  assign a16       = wr_addr[15:0];
  assign at_555_12 = (a12 == 12'h555);
  assign at_2aa    = (a16 == 16'h02AA) || (a16 == 16'h2AAA);
  assign at_555_16 = (a16 == 16'h0555) || (a16 == 16'h5555);

  assign status      = status_q;
  assign master_lock = lock_q;

  always_comb begin
    state_d     = state_q;
    status_d    = status_q;
    lock_d      = lock_q;
    prog_we     = 1'b0;
    erase_start = 1'b0;
    erase_kind  = ER_SECTOR;

    if (busy_expire) begin
      status_d = (status_q | STATUS_READY) & ~STATUS_ERBSY;
      if (state_q == ST_ERASE_WAIT) state_d = ST_NORMAL;
    end

    if (wr_en) begin
      unique case (state_q)
        ST_NORMAL, ST_STATUS, ST_ID, ST_UID: begin
          case (wr_data)
            8'hF0, 8'hFF: state_d = ST_NORMAL;
            8'h90:        state_d = ST_ID;
            8'h40, 8'h10: state_d = ST_PROG_ARM;
            8'h50: begin
              status_d = STATUS_READY;
              state_d  = ST_STATUS;
            end
            8'h20:        state_d = ST_BLK_ARM;
            8'h60:        state_d = ST_LOCK_ARM;
            8'h70:        state_d = ST_STATUS;
            8'hAA:        if (at_555_12) state_d = ST_UNLK1;
            default:      ;
          endcase
        end
        ST_UNLK1: begin
          if (wr_data == 8'h55 && at_2aa) state_d = ST_UNLK2;
          else                            state_d = ST_NORMAL;
        end
        ST_UNLK2: begin
          state_d = ST_NORMAL;
          if (at_555_16) begin
            case (wr_data)
              8'h90:   state_d = ST_UID;
              8'h80:   state_d = ST_ERP1;
              8'hA0:   state_d = ST_BYTE_PROG;
              default: state_d = ST_NORMAL;
            endcase
          end
        end
        ST_ERP1: if (wr_data == 8'hAA && at_555_12) state_d = ST_ERP2;
        ST_ERP2: if (wr_data == 8'h55 && at_2aa)    state_d = ST_ERP3;
        ST_ERP3: begin
          if (wr_data == 8'h10 && at_555_12) begin
            erase_start = 1'b1;
            erase_kind  = ER_CHIP;
            status_d    = STATUS_ERBSY;
            state_d     = ST_ERASE_WAIT;
          end else if (wr_data == 8'h30) begin
            erase_start = 1'b1;
            erase_kind  = ER_SECTOR;
            status_d    = STATUS_ERBSY;
            state_d     = ST_ERASE_WAIT;
          end
        end
        ST_BYTE_PROG: begin
          prog_we = 1'b1;
          state_d = ST_NORMAL;
        end
        ST_PROG_ARM: begin
          prog_we  = 1'b1;
          status_d = STATUS_READY;
          state_d  = ST_STATUS;
        end
        ST_BLK_ARM: begin
          if (wr_data == 8'hD0) begin
            erase_start = 1'b1;
            erase_kind  = ER_BLOCK;
            status_d    = 8'h00;
            state_d     = ST_STATUS;
          end
        end
        ST_LOCK_ARM: begin
          if (wr_data == 8'hF1)      lock_d = 1'b1;
          else if (wr_data == 8'hD0) lock_d = 1'b0;
          state_d = ST_NORMAL;
        end
        ST_ERASE_WAIT: ;
        default: state_d = ST_NORMAL;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_ID, ST_UID: rd_mode = RD_ID;
      ST_STATUS, ST_PROG_ARM, ST_BLK_ARM, ST_LOCK_ARM, ST_ERASE_WAIT:
                     rd_mode = RD_STATUS;
      default:       rd_mode = RD_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_NORMAL;
      status_q <= STATUS_READY;
      lock_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      lock_q   <= lock_d;
    end
  end

  // R4: an armed program write always lands in status read showing ready
  p_prog_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG_ARM && wr_en) |=> (state_q == ST_STATUS && status_q == 8'h80));

  // R12: expiry in the unlock erase wait returns to array read with ready set
  p_wait_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE_WAIT && busy_expire) |=>
      (state_q == ST_NORMAL && status_q[7] && !status_q[3]));

  // R6: the lock flag only moves on a write in the lock-armed state
  p_lock_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $past(state_q == ST_LOCK_ARM && wr_en));

  // R7: a wrong second unlock byte falls back to array read
  p_unlock_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNLK1 && wr_en && wr_data != 8'h55) |=> state_q == ST_NORMAL);

  // R10: the erase wait ignores writes until expiry
  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE_WAIT && !busy_expire) |=> state_q == ST_ERASE_WAIT);

endmodule

// File: rtl/flash_cmd_interp.sv
module flash_cmd_interp
  import fcmd_pkg::*;
#(
  parameter int         BUS_AW          = 16,
  parameter int         ARR_AW          = 11,
  parameter int         SECT_SMALL_LOG2 = 8,
  parameter int         SECT_LARGE_LOG2 = 10,
  parameter bit         LARGE_SECTOR    = 1'b0,
  parameter int         BLOCK_LOG2      = 10,
  parameter int         BUSY_SMALL      = 300,
  parameter int         BUSY_LARGE      = 900,
  parameter int         BUSY_BLOCK      = 1200,
  parameter int         BUSY_CHIP       = 2100,
  parameter logic [7:0] MFR_ID          = 8'hC2,
  parameter logic [7:0] DEV_ID          = 8'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [1:0]        rd_mode,
  output logic              master_lock
);

  localparam int SECT_LOG2  = LARGE_SECTOR ? SECT_LARGE_LOG2 : SECT_SMALL_LOG2;
  localparam int BUSY_SECT  = LARGE_SECTOR ? BUSY_LARGE : BUSY_SMALL;
  localparam int BUSY_MAX_A = (BUSY_SECT > BUSY_BLOCK) ? BUSY_SECT : BUSY_BLOCK;
  localparam int BUSY_MAX   = (BUSY_MAX_A > BUSY_CHIP) ? BUSY_MAX_A : BUSY_CHIP;
  localparam int CNT_W      = $clog2(BUSY_MAX + 1);
  localparam logic [ARR_AW-1:0] SECT_SPAN  = ARR_AW'((1 << SECT_LOG2) - 1);
  localparam logic [ARR_AW-1:0] BLOCK_SPAN = ARR_AW'((1 << BLOCK_LOG2) - 1);

  logic              rst_meta_q, rst_sync_q;
  logic              sweep_busy, wr_acc, prog_we, erase_start, busy_expire;
  erase_kind_e       erase_kind;
  rd_mode_e          mode;
  logic [7:0]        status, arr_byte;
  logic [ARR_AW-1:0] a_arr, er_base, er_last;
  logic [CNT_W-1:0]  busy_ticks;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign wr_acc = wr_en && !sweep_busy;
  assign a_arr  = wr_addr[ARR_AW-1:0];

  fcmd_decoder #(.BUS_AW(BUS_AW)) u_dec (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .wr_en       (wr_acc),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy_expire (busy_expire),
    .rd_mode     (mode),
    .status      (status),
    .master_lock (master_lock),
    .prog_we     (prog_we),
    .erase_start (erase_start),
    .erase_kind  (erase_kind)
  );

  always_comb begin
    case (erase_kind)
      ER_CHIP: begin
        er_base    = '0;
        er_last    = '1;
        busy_ticks = CNT_W'(BUSY_CHIP);
      end
      ER_BLOCK: begin
        er_base    = a_arr & ~BLOCK_SPAN;
        er_last    = a_arr | BLOCK_SPAN;
        busy_ticks = CNT_W'(BUSY_BLOCK);
      end
      default: begin
        er_base    = a_arr & ~SECT_SPAN;
        er_last    = a_arr | SECT_SPAN;
        busy_ticks = CNT_W'(BUSY_SECT);
      end
    endcase
  end

  fcmd_array #(.ARR_AW(ARR_AW)) u_arr (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .prog_we    (prog_we),
    .prog_addr  (a_arr),
    .prog_data  (wr_data),
    .er_start   (erase_start),
    .er_base    (er_base),
    .er_last    (er_last),
    .rd_addr    (rd_addr),
    .rd_byte    (arr_byte),
    .sweep_busy (sweep_busy)
  );

  fcmd_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (erase_start),
    .load_val (busy_ticks),
    .expire   (busy_expire)
  );

  always_comb begin
    case (mode)
      RD_ID:     rd_data = rd_addr[0] ? DEV_ID : MFR_ID;
      RD_STATUS: rd_data = status;
      default:   rd_data = arr_byte;
    endcase
  end

  assign rd_mode = mode;

  // R13: writes during a sweep leave the lock flag untouched
  p_drop_in_sweep_r13: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sweep_busy && wr_en) |=> $stable(master_lock));

  // R10: an unlock erase never starts a new sweep while one is running
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sweep_busy |-> !erase_start);

endmodule

// File: tb/test_flash_cmd_interp.sv
`timescale 1ns/1ps
module test_flash_cmd_interp;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [10:0] rd_addr;
  logic [7:0]  rd_data;
  logic [1:0]  rd_mode;
  logic        master_lock;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [1:0] q_mode [$];
  logic [7:0] q_data [$];
  bit         q_use  [$];
  string      q_tag  [$];

  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_ST = 2'd2;

  always #2.5 clk = ~clk;

  flash_cmd_interp #(
    .BUS_AW(16), .ARR_AW(11), .SECT_SMALL_LOG2(8), .SECT_LARGE_LOG2(10),
    .LARGE_SECTOR(1'b0), .BLOCK_LOG2(10), .BUSY_SMALL(300), .BUSY_LARGE(900),
    .BUSY_BLOCK(1200), .BUSY_CHIP(2100), .MFR_ID(8'hC2), .DEV_ID(8'h5B)
  ) i_flash_cmd_interp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_mode(rd_mode), .master_lock(master_lock)
  );

  // monitor: pops expected reads and compares mid-cycle
  always @(negedge clk) begin
    if (q_mode.size() > 0) begin
      logic [1:0] em;
      logic [7:0] ed;
      bit         eu;
      string      et;
      em = q_mode.pop_front();
      ed = q_data.pop_front();
      eu = q_use.pop_front();
      et = q_tag.pop_front();
      checks++;
      if (rd_mode !== em || (eu && rd_data !== ed)) begin
        errors++;
        $display("FAIL %s: mode=%0d data=%02h expected mode=%0d data=%02h",
                 et, rd_mode, rd_data, em, ed);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [10:0] a, logic [1:0] m, logic [7:0] d, bit use_d, string tag);
    rd_addr = a;
    q_mode.push_back(m);
    q_data.push_back(d);
    q_use.push_back(use_d);
    q_tag.push_back(tag);
    step(1);
  endtask

  task automatic lock_chk(logic e, string tag);
    checks++;
    if (master_lock !== e) begin
      errors++;
      $display("FAIL %s: master_lock=%0b expected %0b", tag, master_lock, e);
    end
  endtask

  task automatic unlock3(logic [15:0] a3, logic [7:0] d3);
    bus_wr(16'h0555, 8'hAA);
    bus_wr(16'h02AA, 8'h55);
    bus_wr(a3, d3);
  endtask

  task automatic prog1(logic [15:0] a, logic [7:0] d);
    bus_wr(16'h0000, 8'h40);
    bus_wr(a, d);
    bus_wr(16'h0000, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    rd_chk(11'h000, M_ARR, 8'h00, 1'b0, "R1 reset mode");
    lock_chk(1'b0, "R1 reset lock");
    bus_wr(16'h0000, 8'h70);
    rd_chk(11'h000, M_ST, 8'h80, 1'b1, "R1 reset status");

    // R10 chip erase through unlock, R9 prefix with 0x2AAA
    unlock3(16'h0555, 8'h80);
    bus_wr(16'h0555, 8'hAA);
    bus_wr(16'h2AAA, 8'h55);
    bus_wr(16'h0555, 8'h10);
    rd_chk(11'h000, M_ST, 8'h08, 1'b1, "R10 chip busy status");
    step(2060);
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h000, M_ST, 8'h08, 1'b1, "R10 write ignored in wait");
    step(100);
    rd_chk(11'h000, M_ARR, 8'hFF, 1'b1, "R12 chip expiry to array");
    rd_chk(11'h7FF, M_ARR, 8'hFF, 1'b1, "R10 chip erased top");

    // R2 read modes and ID select
    bus_wr(16'h0000, 8'h90);
    rd_chk(11'h000, M_ID, 8'hC2, 1'b1, "R2 ID manufacturer");
    rd_chk(11'h001, M_ID, 8'h5B, 1'b1, "R2 ID device");
    bus_wr(16'h0000, 8'h70);
    rd_chk(11'h000, M_ST, 8'h80, 1'b1, "R2 status select");
    bus_wr(16'h0000, 8'hF0);
    rd_chk(11'h000, M_ARR, 8'hFF, 1'b1, "R2 F0 to array");
    bus_wr(16'h0000, 8'h90);
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h000, M_ARR, 8'hFF, 1'b1, "R2 FF to array");

    // R4 single-write program
    bus_wr(16'h0000, 8'h40);
    bus_wr(16'h0100, 8'h3C);
    rd_chk(11'h100, M_ST, 8'h80, 1'b1, "R4 program status");
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h100, M_ARR, 8'h3C, 1'b1, "R4 programmed byte 40");
    bus_wr(16'h0000, 8'h10);
    bus_wr(16'h0101, 8'hA5);
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h101, M_ARR, 8'hA5, 1'b1, "R4 programmed byte 10");

    // R5 block erase, R13 drop, R3 clear status
    prog1(16'h03FF, 8'h77);
    prog1(16'h0400, 8'h66);
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'h33);
    rd_chk(11'h000, M_ST, 8'h80, 1'b1, "R5 non-confirm ignored");
    bus_wr(16'h0123, 8'hD0);
    rd_chk(11'h000, M_ST, 8'h00, 1'b1, "R5 block busy status");
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h000, M_ST, 8'h00, 1'b1, "R13 write dropped in sweep");
    step(1030);
    bus_wr(16'h0000, 8'h50);
    rd_chk(11'h000, M_ST, 8'h80, 1'b1, "R3 clear status while busy");
    step(200);
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h3FF, M_ARR, 8'hFF, 1'b1, "R5 block end erased");
    rd_chk(11'h123, M_ARR, 8'hFF, 1'b1, "R5 block inner erased");
    rd_chk(11'h400, M_ARR, 8'h66, 1'b1, "R5 next block kept");

    // R12 block expiry sets ready
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0500, 8'hD0);
    rd_chk(11'h000, M_ST, 8'h00, 1'b1, "R5 second block busy");
    step(1250);
    rd_chk(11'h000, M_ST, 8'h80, 1'b1, "R12 block expiry ready");
    bus_wr(16'h0000, 8'hFF);
    rd_chk(11'h400, M_ARR, 8'hFF, 1'b1, "R5 second block erased");

    // R6 lock flag
    bus_wr(16'h0000, 8'h60);
    bus_wr(16'h0000, 8'hF1);
    lock_chk(1'b1, "R6 lock set");
    rd_chk(11'h000, M_ARR, 8'hFF, 1'b1, "R6 back to array");
    bus_wr(16'h0000, 8'h60);
    bus_wr(16'h0000, 8'h12);
    lock_chk(1'b1, "R6 other byte keeps lock");
    bus_wr(16'h0000, 8'h60);
    bus_wr(16'h0000, 8'hD0);
    lock_chk(1'b0, "R6 lock cleared");

    // R7 broken unlock arms nothing
    bus_wr(16'h0555, 8'hAA);
    bus_wr(16'h0123, 8'h55);
    bus_wr(16'h0555, 8'hA0);
    bus_wr(16'h0200, 8'h42);
    rd_chk(11'h200, M_ARR, 8'hFF, 1'b1, "R7 broken unlock no program");

    // R8 unlock byte program with alternate addresses
    bus_wr(16'h1555, 8'hAA);
    bus_wr(16'h2AAA, 8'h55);
    bus_wr(16'h5555, 8'hA0);
    bus_wr(16'h0201, 8'h5A);
    rd_chk(11'h201, M_ARR, 8'h5A, 1'b1, "R8 unlock byte program");
    unlock3(16'h0555, 8'h90);
    rd_chk(11'h000, M_ID, 8'hC2, 1'b1, "R8 unlock ID");
    bus_wr(16'h0000, 8'h70);
    rd_chk(11'h000, M_ST, 8'h80, 1'b1, "R2 status from unlock ID");
    unlock3(16'h0555, 8'hF0);
    rd_chk(11'h000, M_ARR, 8'hFF, 1'b1, "R8 unlock F0 to array");
    unlock3(16'h0555, 8'h33);
    bus_wr(16'h0202, 8'h11);
    rd_chk(11'h202, M_ARR, 8'hFF, 1'b1, "R8 bad third byte");
    unlock3(16'h0777, 8'hA0);
    bus_wr(16'h0203, 8'h22);
    rd_chk(11'h203, M_ARR, 8'hFF, 1'b1, "R8 bad third address");

    // R9 junk in prefix, R11 sector erase
    prog1(16'h02FF, 8'h11);
    prog1(16'h0300, 8'h22);
    prog1(16'h01FF, 8'h33);
    unlock3(16'h0555, 8'h80);
    bus_wr(16'h0000, 8'h12);
    bus_wr(16'h0555, 8'hAA);
    bus_wr(16'h02AA, 8'h99);
    bus_wr(16'h02AA, 8'h55);
    bus_wr(16'h0100, 8'h77);
    bus_wr(16'h02A0, 8'h30);
    rd_chk(11'h000, M_ST, 8'h08, 1'b1, "R9 prefix survives junk");
    step(310);
    rd_chk(11'h2FF, M_ARR, 8'hFF, 1'b1, "R11 sector end erased");
    rd_chk(11'h201, M_ARR, 8'hFF, 1'b1, "R11 sector inner erased");
    rd_chk(11'h300, M_ARR, 8'h22, 1'b1, "R11 next sector kept");
    rd_chk(11'h1FF, M_ARR, 8'h33, 1'b1, "R11 prior sector kept");

    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule